// File: doc/BRIEF.md
# Outstanding-Request Tracker with Round-Trip Deadline

This block is the checking half of a random-traffic tester for a coherent memory system. Each request handed to the system under test is also registered here with its transaction ID, message type, the data its reply must carry and a round-trip limit in cycles. When a reply comes back with the same ID, its data is compared against the registered value. A match is counted as a passed transaction and the slot is released. A mismatch flags a data-consistency error.

Every occupied slot runs its own countdown, and all slots are watched in every cycle. If a slot runs out of time with no reply, the block declares a possible deadlock and freezes. In the frozen state it ignores all traffic, and its flags hold until a synchronous reset. Misuse of the table is flagged separately: a second injection into a busy slot, or a reply for an ID that nothing is waiting on.

Top module: `ort_tracker`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), all eight slots are empty, `pass_count` is 0, every error flag and `halted` are 0, and `inj_ready` is 1.
- R2: `inj_ready` is 1 exactly when `halted` is 0 and the slot selected by the 3-bit `inj_id` is empty. An injection with `inj_valid` and `inj_ready` both high occupies that slot from the next edge, storing the type, the data and the limit.
- R3: A reply (`rsp_valid`) to an occupied slot whose `rsp_data` equals the stored data raises `pass_count` by one at the next edge and empties the slot.
- R4: A reply to an occupied slot with different data sets `data_err` at the next edge and empties the slot. `pass_count` is unchanged and the block does not halt.
- R5: A slot injected with limit N accepts its reply during any of the N+1 cycles that follow the injection cycle. If none arrives, `deadlock_err` and `halted` both go to 1 at the edge that ends the last of those cycles.
- R6: If a reply reaches a slot in that slot's final cycle, the reply is handled and no deadlock is raised.
- R7: An injection into an occupied slot while not halted sets `misuse_err`. It leaves the stored entry unchanged, so the original data still passes.
- R8: A reply for an empty slot while not halted sets `unexp_err` and leaves `pass_count` unchanged.
- R9: While `halted` is 1, injections and replies have no effect, `pass_count` holds, `inj_ready` is 0, and all flags stay set until reset.
- R10: `pass_count` is 16 bits wide and stops at 65535. Further passes leave it there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inj_valid | input | 1 | Injection present this cycle |
| inj_id | input | 3 | Transaction ID / slot of the injection |
| inj_type | input | 4 | Message type of the injected request |
| inj_data | input | 32 | Data the reply must carry |
| inj_rtt | input | 16 | Round-trip limit in cycles |
| inj_ready | output | 1 | Slot for `inj_id` is free and the block is running |
| rsp_valid | input | 1 | Reply present this cycle |
| rsp_id | input | 3 | Transaction ID of the reply |
| rsp_data | input | 32 | Data returned by the reply |
| pass_count | output | 16 | Saturating count of passed transactions |
| data_err | output | 1 | Sticky data-consistency error |
| deadlock_err | output | 1 | Sticky round-trip timeout error |
| misuse_err | output | 1 | Sticky injection-into-busy-slot error |
| unexp_err | output | 1 | Sticky reply-to-empty-slot error |
| halted | output | 1 | Test stopped after a timeout |

## Verification
The properties assume that `inj_id`, `rsp_id` and the data inputs carry known values in every cycle where their valid bit is high. They also assume that reset is held for at least one edge before traffic begins. The stimulus always drives IDs and data to defined values and clears both valid bits in idle cycles. It issues a reset before each scenario. It also keeps the round-trip limits small enough in the timeout scenarios, and large enough in the long pass-count run, that expiry happens only where the scenario intends it.

// File: rtl/ort_pkg.sv
`timescale 1ns/1ps
package ort_pkg;

  // Outcome of the reply port in one cycle.
  typedef enum logic [1:0] {
    RSP_NONE     = 2'd0,
    RSP_MATCH    = 2'd1,
    RSP_MISMATCH = 2'd2,
    RSP_STRAY    = 2'd3
  } rsp_class_e;

  function automatic rsp_class_e classify_rsp(input logic fire,
                                              input logic slot_busy,
                                              input logic same_data);
    if (!fire)           return RSP_NONE;
    else if (!slot_busy) return RSP_STRAY;
    else if (same_data)  return RSP_MATCH;
    else                 return RSP_MISMATCH;
  endfunction

endpackage

// File: rtl/ort_entry.sv
`timescale 1ns/1ps
module ort_entry #(
  parameter int TYPE_W = 4,
  parameter int DATA_W = 32,
  parameter int TMR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc,
  input  logic              hit,
  input  logic [TYPE_W-1:0] kind_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic [TMR_W-1:0]  rtt_in,
  output logic              busy,
  output logic [DATA_W-1:0] exp_data,
  output logic              timeout
);

  logic [TYPE_W-1:0] kind_q;
  logic [DATA_W-1:0] data_q;
  logic [TMR_W-1:0]  timer_q;
  logic              busy_q;

  function automatic logic [TMR_W-1:0] tick_down(input logic [TMR_W-1:0] t);
    return (t == '0) ? t : t - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      timer_q <= '0;
    end else if (hit) begin
      busy_q  <= 1'b0;
    end else if (alloc) begin
      busy_q  <= 1'b1;
      timer_q <= rtt_in;
    end else if (busy_q) begin
      timer_q <= tick_down(timer_q);
    end
  end

  always_ff @(posedge clk) begin
    if (alloc && !hit) begin
      kind_q <= kind_in;
      data_q <= data_in;
    end
  end

  assign busy     = busy_q;
  assign exp_data = data_q;
  // A reply that lands in the final cycle takes precedence over expiry.
  assign timeout  = busy_q && (timer_q == '0) && !hit;

  // R7
  entry_payload_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !hit) |=> ($stable(kind_q) && $stable(data_q) && busy_q));

endmodule

// File: rtl/ort_sat_cnt.sv
`timescale 1ns/1ps
module ort_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] TOP = '1;

  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] v);
    return (v == TOP) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)     count <= '0;
    else if (en) count <= sat_inc(count);
  end

  // R10
  count_sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (count == TOP) |=> (count == TOP));

endmodule

// File: rtl/ort_tracker.sv
`timescale 1ns/1ps
module ort_tracker #(
  parameter int ID_W   = 3,
  parameter int TYPE_W = 4,
  parameter int DATA_W = 32,
  parameter int TMR_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inj_valid,
  input  logic [ID_W-1:0]   inj_id,
  input  logic [TYPE_W-1:0] inj_type,
  input  logic [DATA_W-1:0] inj_data,
  input  logic [TMR_W-1:0]  inj_rtt,
  output logic              inj_ready,
  input  logic              rsp_valid,
  input  logic [ID_W-1:0]   rsp_id,
  input  logic [DATA_W-1:0] rsp_data,
  output logic [CNT_W-1:0]  pass_count,
  output logic              data_err,
  output logic              deadlock_err,
  output logic              misuse_err,
  output logic              unexp_err,
  output logic              halted
);
  import ort_pkg::*;

  localparam int DEPTH = 1 << ID_W;

  logic [DEPTH-1:0]  busy_vec;
  logic [DEPTH-1:0]  timeout_vec;
  logic [DEPTH-1:0]  alloc_vec;
  logic [DEPTH-1:0]  hit_vec;
  logic [DATA_W-1:0] exp_data [DEPTH];

  // Named internal events.
  rsp_class_e rsp_class;
  logic       inj_accept;
  logic       inj_misuse;
  logic       expire_evt;
  logic       pass_evt;

  assign rsp_class  = classify_rsp(rsp_valid && !halted, busy_vec[rsp_id],
                                   rsp_data == exp_data[rsp_id]);
  assign inj_ready  = !halted && !busy_vec[inj_id];
  assign inj_accept = inj_valid && inj_ready;
  assign inj_misuse = inj_valid && !halted && busy_vec[inj_id];
  assign expire_evt = !halted && (|timeout_vec);
  assign pass_evt   = (rsp_class == RSP_MATCH);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign alloc_vec[i] = inj_accept && (inj_id == ID_W'(i));
    assign hit_vec[i]   = ((rsp_class == RSP_MATCH) || (rsp_class == RSP_MISMATCH))
                          && (rsp_id == ID_W'(i));

    ort_entry #(.TYPE_W(TYPE_W), .DATA_W(DATA_W), .TMR_W(TMR_W)) u_entry (
      .clk      (clk),
      .rst      (rst),
      .alloc    (alloc_vec[i]),
      .hit      (hit_vec[i]),
      .kind_in  (inj_type),
      .data_in  (inj_data),
      .rtt_in   (inj_rtt),
      .busy     (busy_vec[i]),
      .exp_data (exp_data[i]),
      .timeout  (timeout_vec[i])
    );
  end

  ort_sat_cnt #(.W(CNT_W)) u_pass (
    .clk   (clk),
    .rst   (rst),
    .en    (pass_evt),
    .count (pass_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_err     <= 1'b0;
      deadlock_err <= 1'b0;
      misuse_err   <= 1'b0;
      unexp_err    <= 1'b0;
      halted       <= 1'b0;
    end else begin
      if (rsp_class == RSP_MISMATCH) data_err   <= 1'b1;
      if (rsp_class == RSP_STRAY)    unexp_err  <= 1'b1;
      if (inj_misuse)                misuse_err <= 1'b1;
      if (expire_evt) begin
        deadlock_err <= 1'b1;
        halted       <= 1'b1;
      end
    end
  end

  // R3
  pass_incr_chk: assert property (@(posedge clk) disable iff (rst)
    (pass_evt && pass_count != '1) |=> (pass_count == $past(pass_count) + 1'b1));

  // R4
  mismatch_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_class == RSP_MISMATCH) |=> (data_err && $stable(pass_count)));

  // R5
  timeout_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (|timeout_vec) |=> (deadlock_err && halted));

  // R7
  misuse_flag_chk: assert property (@(posedge clk) disable iff (rst)
    inj_misuse |=> misuse_err);

  // R8
  stray_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_class == RSP_STRAY) |=> (unexp_err && $stable(pass_count)));

  // R9
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && deadlock_err && $stable(pass_count) && !inj_ready));

  // R5
  halt_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> deadlock_err);

endmodule

// File: tb/test_ort_tracker.sv
`timescale 1ns/1ps
module test_ort_tracker;

  logic        clk = 1'b0;
  logic        rst;
  logic        inj_valid, rsp_valid;
  logic [2:0]  inj_id, rsp_id;
  logic [3:0]  inj_type;
  logic [31:0] inj_data, rsp_data;
  logic [15:0] inj_rtt;
  logic        inj_ready;
  logic [15:0] pass_count;
  logic        data_err, deadlock_err, misuse_err, unexp_err, halted;

  always #2 clk = ~clk;

  ort_tracker i_ort_tracker (
    .clk(clk), .rst(rst),
    .inj_valid(inj_valid), .inj_id(inj_id), .inj_type(inj_type),
    .inj_data(inj_data), .inj_rtt(inj_rtt), .inj_ready(inj_ready),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data),
    .pass_count(pass_count), .data_err(data_err), .deadlock_err(deadlock_err),
    .misuse_err(misuse_err), .unexp_err(unexp_err), .halted(halted)
  );

  typedef struct {
    int    pass;
    bit    de, dl, me, ue, h, rdy;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  bit   finished = 0;

  // Reference model state.
  bit          mv [8];
  logic [31:0] md [8];
  int          mt [8];
  int          mpass;
  bit          mde, mdl, mme, mue, mh;

  function automatic void model_clear();
    for (int i = 0; i < 8; i++) begin mv[i] = 0; md[i] = '0; mt[i] = 0; end
    mpass = 0; mde = 0; mdl = 0; mme = 0; mue = 0; mh = 0;
  endfunction

  function automatic void push_exp(int iid, string tag);
    exp_t e;
    e.pass = mpass; e.de = mde; e.dl = mdl; e.me = mme; e.ue = mue; e.h = mh;
    e.rdy = !mh && !mv[iid]; e.tag = tag;
    q.push_back(e);
  endfunction

  task automatic do_reset(string tag);
    @(negedge clk);
    rst = 1; inj_valid = 0; rsp_valid = 0; inj_id = 0; rsp_id = 0;
    inj_type = 0; inj_data = 0; rsp_data = 0; inj_rtt = 0;
    model_clear();
    push_exp(0, tag);
    @(posedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  // Driver: applies one cycle of stimulus and predicts the outputs after the edge.
  task automatic step(bit iv, int iid, logic [31:0] idat, int irtt,
                      bit rv, int rid, logic [31:0] rdat, string tag);
    bit hit, expire;
    @(negedge clk);
    inj_valid = iv; inj_id = 3'(iid); inj_type = 4'(iid + 3);
    inj_data = idat; inj_rtt = 16'(irtt);
    rsp_valid = rv; rsp_id = 3'(rid); rsp_data = rdat;
    if (!mh) begin
      hit = rv && mv[rid];
      expire = 0;
      for (int i = 0; i < 8; i++)
        if (mv[i] && mt[i] == 0 && !(hit && rid == i)) expire = 1;
      if (rv && !mv[rid]) mue = 1;
      for (int i = 0; i < 8; i++)
        if (mv[i] && !(hit && rid == i) && mt[i] != 0) mt[i]--;
      if (iv && mv[iid]) mme = 1;
      else if (iv) begin mv[iid] = 1; md[iid] = idat; mt[iid] = irtt; end
      if (hit) begin
        if (md[rid] == rdat) begin if (mpass < 65535) mpass++; end
        else mde = 1;
        mv[rid] = 0;
      end
      if (expire) begin mdl = 1; mh = 1; end
    end
    push_exp(iid, tag);
    @(posedge clk);
  endtask

  task automatic idle(int iid, string tag);
    step(0, iid, 0, 0, 0, 0, 0, tag);
  endtask

  // Monitor: pops expected items and compares after each edge.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0 && !finished) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (pass_count != 16'(e.pass) || data_err != e.de || deadlock_err != e.dl ||
          misuse_err != e.me || unexp_err != e.ue || halted != e.h || inj_ready != e.rdy) begin
        n_fail++;
        $display("FAIL %s: actual pass=%0d de=%0b dl=%0b me=%0b ue=%0b h=%0b rdy=%0b expected pass=%0d de=%0b dl=%0b me=%0b ue=%0b h=%0b rdy=%0b",
                 e.tag, pass_count, data_err, deadlock_err, misuse_err, unexp_err, halted, inj_ready,
                 e.pass, e.de, e.dl, e.me, e.ue, e.h, e.rdy);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1; inj_valid = 0; rsp_valid = 0; inj_id = 0; rsp_id = 0;
    inj_type = 0; inj_data = 0; rsp_data = 0; inj_rtt = 0;
    do_reset("R1 reset state");

    // R2 and R3: inject then matching reply
    step(1, 0, 32'hA5A5_0001, 20, 0, 0, 0, "R2 accept slot0");
    step(0, 0, 0, 0, 1, 0, 32'hA5A5_0001, "R3 match slot0");
    step(1, 1, 32'h1234_5678, 20, 0, 0, 0, "R2 accept slot1");
    // R4: wrong data
    step(0, 1, 0, 0, 1, 1, 32'h1234_5679, "R4 mismatch slot1");
    idle(1, "R4 slot freed, no halt");
    do_reset("R1 reset clears flags");

    // R7: double injection, original kept
    step(1, 2, 32'hBEEF_0002, 30, 0, 0, 0, "R2 accept slot2");
    step(1, 2, 32'hDEAD_0002, 30, 0, 0, 0, "R7 misuse slot2");
    step(0, 2, 0, 0, 1, 2, 32'hBEEF_0002, "R7 original data passes");
    // R8: reply to empty slot
    step(0, 5, 0, 0, 1, 5, 32'h0, "R8 stray reply");
    do_reset("R1 reset");

    // R6: reply in final cycle of limit 3
    step(1, 3, 32'h0000_0333, 3, 0, 0, 0, "R2 accept slot3");
    idle(3, "R6 wait");
    idle(3, "R6 wait");
    idle(3, "R6 wait");
    step(0, 3, 0, 0, 1, 3, 32'h0000_0333, "R6 last-cycle reply wins");
    idle(3, "R6 no deadlock");
    do_reset("R1 reset");

    // R10: long pipelined run past saturation
    for (int t = 0; t < 65545; t++)
      step(1, t % 8, 32'(t * 7 + 1), 100, t > 0, (t + 7) % 8, 32'((t - 1) * 7 + 1), "R10 R3 pipelined pass");
    step(0, 0, 0, 0, 1, 65544 % 8, 32'(65544 * 7 + 1), "R10 saturated");
    do_reset("R1 reset after run");

    // R5 and R9: timeout halts the test
    step(1, 4, 32'h4444_0004, 2, 0, 0, 0, "R2 accept slot4");
    step(1, 6, 32'h6666_0006, 50, 0, 0, 0, "R2 accept slot6");
    idle(7, "R5 counting");
    idle(7, "R5 expiry edge");
    idle(7, "R5 halted");
    step(1, 7, 32'h7777_0007, 9, 1, 6, 32'h6666_0006, "R9 traffic ignored");
    step(0, 0, 0, 0, 1, 0, 32'h0, "R9 stray ignored");
    do_reset("R1 reset clears halt");

    @(posedge clk); #2;
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule